// File: doc/BRIEF.md
# Half-Bridge Shoot-Through Interlock

This block sits between a PWM generator and the gate drivers of a set of half-bridges. Each phase has two active-low commands, one for the high-side switch and one for the low-side switch. The block turns them into active-high gate enables. It never lets both switches of one leg conduct at once, and it inserts a programmable dead time whenever a leg changes from one switch to the other.

If a phase sees both of its commands asserted together, the block switches that leg fully off and latches the condition. Other phases keep running. A shared active-low fault line reports the condition. The latch is not released when the commands simply become legal again. It is released only when the command that caused the overlap, meaning the one that went on later, produces a fresh turn-on edge while its partner is off.

Every command passes through a synchroniser before any decision is made. The dead time is a clock-cycle count. Its default of 220 cycles gives 2.2 µs at a 100 MHz clock.

Top module: `arm_interlock`

## Requirements
- R1: A command is on when its pin is low, and a gate is on when its output is high. With no conflict and the dead time met, a gate output follows its command on the third rising clock edge after the command pin changes.
- R2: The high and low gate outputs of one phase are never high in the same cycle.
- R3: When both commands of a phase are on together, both gates of that phase go low and `fault_n` goes low on the same edge. That edge is the third rising edge after the overlap appears on the pins.
- R4: Once tripped, a phase keeps both gates low even after its commands return to a legal pattern. This includes a return to all-off.
- R5: A tripped phase is released only by an on-going edge (high-to-low on the pin) of the command that went on later, arriving while the partner command is off. An on-going edge of the earlier command does not release it.
- R6: If both commands of a phase went on in the same cycle, an on-going edge of either command releases the trip, provided the partner command is off.
- R7: `fault_n` is low exactly while at least one phase is tripped. A trip in one phase does not change the gates of the other phases.
- R8: A gate may rise only after its partner gate has been low for at least `DEAD_CYCLES` cycles. When a leg is commanded straight from one switch to the other, the incoming gate rises exactly `DEAD_CYCLES` edges after the outgoing gate falls.
- R9: A synchronous reset drives all gates low, sets `fault_n` high, clears all trips and marks every dead-time window as already elapsed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_hi_n | input | NUM_PHASES | High-side commands, active low |
| cmd_lo_n | input | NUM_PHASES | Low-side commands, active low |
| gate_hi | output | NUM_PHASES | High-side gate enables, active high |
| gate_lo | output | NUM_PHASES | Low-side gate enables, active high |
| fault_n | output | 1 | Shared trip indication, active low |

## Verification
The latency properties assume that a command pin holds its level for at least three clock cycles around each change. A rising gate or a falling fault can then be traced back to a pin level exactly three edges earlier. The bench changes inputs only on falling clock edges and holds every vector for sixteen cycles, well beyond the synchroniser depth and the reduced dead time it uses. The dead-time property assumes that reset is asserted from the first clock edge. The bench does this, so the checker's own elapsed-time counters start saturated, in line with R9.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  // Dead time in clock cycles: 2.2 us at 100 MHz.
  localparam int unsigned DEFAULT_DEAD = 220;

  // One leg of a half-bridge, in "on" polarity.
  typedef struct packed {
    logic hi;
    logic lo;
  } leg_t;

endpackage

// File: rtl/ilk_sync.sv
module ilk_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= {WIDTH{RST_VAL}};
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/ilk_deadtime.sv
// Counts how long the partner gate has been off; grants turn-on once the
// dead-time window has elapsed (saturating counter).
module ilk_deadtime #(
  parameter int unsigned DEAD = 220
) (
  input  logic clk,
  input  logic rst,
  input  logic partner_on,
  output logic ready
);

  localparam int unsigned CW = (DEAD < 2) ? 1 : $clog2(DEAD + 1);
  localparam logic [CW-1:0] SAT    = CW'(DEAD);
  localparam logic [CW-1:0] THRESH = (DEAD == 0) ? '0 : CW'(DEAD - 1);

  logic [CW-1:0] off_cnt;

  always_ff @(posedge clk) begin
    if (rst)             off_cnt <= SAT;
    else if (partner_on) off_cnt <= '0;
    else if (off_cnt != SAT) off_cnt <= off_cnt + 1'b1;
  end

  // Grant looks one cycle ahead so the gate rises exactly DEAD edges later.
  assign ready = (off_cnt >= THRESH);

endmodule

// File: rtl/ilk_phase.sv
// One leg: overlap trip, latch with "later input" release, gate registers.
module ilk_phase
  import ilk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  leg_t req,        // synchronised commands, on = 1
  input  logic hi_ready,   // dead time elapsed for high side
  input  logic lo_ready,   // dead time elapsed for low side
  output leg_t gate,       // registered gate enables
  output logic trip_d      // next-state of the trip latch
);

  leg_t req_prev;
  leg_t late_q, late_d;
  logic trip_q;
  leg_t turn_on;
  logic release_now;

  // On-going edge of each synchronised command.
  assign turn_on.hi = req.hi & ~req_prev.hi;
  assign turn_on.lo = req.lo & ~req_prev.lo;

  assign release_now = (late_q.hi & turn_on.hi & ~req.lo) |
                       (late_q.lo & turn_on.lo & ~req.hi);

  always_comb begin
    trip_d = trip_q;
    late_d = late_q;
    if (trip_q) begin
      if (release_now) begin
        trip_d = 1'b0;
        late_d = '0;
      end
    end else if (req.hi && req.lo) begin
      trip_d = 1'b1;
      late_d = turn_on;
      if (turn_on == '0) late_d = '{hi: 1'b1, lo: 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_prev <= '0;
      late_q   <= '0;
      trip_q   <= 1'b0;
      gate     <= '0;
    end else begin
      req_prev <= req;
      late_q   <= late_d;
      trip_q   <= trip_d;
      gate.hi  <= req.hi & ~req.lo & ~trip_d & hi_ready & ~gate.lo;
      gate.lo  <= req.lo & ~req.hi & ~trip_d & lo_ready & ~gate.hi;
    end
  end

endmodule

// File: rtl/arm_interlock.sv
module arm_interlock
  import ilk_pkg::*;
#(
  parameter int unsigned NUM_PHASES  = 3,
  parameter int unsigned DEAD_CYCLES = DEFAULT_DEAD,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PHASES-1:0] cmd_hi_n,
  input  logic [NUM_PHASES-1:0] cmd_lo_n,
  output logic [NUM_PHASES-1:0] gate_hi,
  output logic [NUM_PHASES-1:0] gate_lo,
  output logic                  fault_n
);

  logic [NUM_PHASES-1:0] hi_n_s, lo_n_s;
  logic [NUM_PHASES-1:0] hi_rdy, lo_rdy, trip_d;

  ilk_sync #(.WIDTH(NUM_PHASES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_hi (
    .clk(clk), .rst(rst), .din(cmd_hi_n), .dout(hi_n_s));

  ilk_sync #(.WIDTH(NUM_PHASES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_lo (
    .clk(clk), .rst(rst), .din(cmd_lo_n), .dout(lo_n_s));

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    leg_t req, gate;

    assign req.hi = ~hi_n_s[p];
    assign req.lo = ~lo_n_s[p];

    // High side waits on the low gate, and vice versa.
    ilk_deadtime #(.DEAD(DEAD_CYCLES)) u_dt_hi (
      .clk(clk), .rst(rst), .partner_on(gate_lo[p]), .ready(hi_rdy[p]));

    ilk_deadtime #(.DEAD(DEAD_CYCLES)) u_dt_lo (
      .clk(clk), .rst(rst), .partner_on(gate_hi[p]), .ready(lo_rdy[p]));

    ilk_phase u_leg (
      .clk(clk), .rst(rst), .req(req),
      .hi_ready(hi_rdy[p]), .lo_ready(lo_rdy[p]),
      .gate(gate), .trip_d(trip_d[p]));

    assign gate_hi[p] = gate.hi;
    assign gate_lo[p] = gate.lo;
  end

  // Fault is registered on the same edge that cuts the gates.
  always_ff @(posedge clk) begin
    if (rst) fault_n <= 1'b1;
    else     fault_n <= ~(|trip_d);
  end

endmodule

// File: rtl/arm_interlock_chk.sv
module arm_interlock_chk #(
  parameter int unsigned NUM_PHASES  = 3,
  parameter int unsigned DEAD_CYCLES = 220
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_PHASES-1:0] cmd_hi_n,
  input logic [NUM_PHASES-1:0] cmd_lo_n,
  input logic [NUM_PHASES-1:0] gate_hi,
  input logic [NUM_PHASES-1:0] gate_lo,
  input logic                  fault_n
);

  localparam int unsigned CW = (DEAD_CYCLES < 2) ? 1 : $clog2(DEAD_CYCLES + 1);
  localparam logic [CW-1:0] SAT = CW'(DEAD_CYCLES);

  // R9: reset clears outputs on the next edge
  assert_reset_state_R9: assert property (@(posedge clk)
    rst |=> (fault_n && gate_hi == '0 && gate_lo == '0));

  // R3: a falling fault is caused by an overlap seen three edges earlier
  assert_fault_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_n) |-> ($past(~cmd_hi_n & ~cmd_lo_n, 3) != '0));

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_chk
    logic [CW-1:0] lo_off, hi_off;

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_off <= SAT;
        hi_off <= SAT;
      end else begin
        if (gate_lo[p]) lo_off <= '0;
        else if (lo_off != SAT) lo_off <= lo_off + 1'b1;
        if (gate_hi[p]) hi_off <= '0;
        else if (hi_off != SAT) hi_off <= hi_off + 1'b1;
      end
    end

    // R2: never both switches of one leg
    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (rst)
      !(gate_hi[p] && gate_lo[p]));

    // R8: dead time respected in both directions
    assert_dead_hi_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_hi[p]) |-> (lo_off >= SAT));
    assert_dead_lo_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_lo[p]) |-> (hi_off >= SAT));

    // R1: a gate only rises for a command that was on three edges earlier
    assert_cmd_hi_R1: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_hi[p]) |-> $past(!cmd_hi_n[p], 3));
    assert_cmd_lo_R1: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_lo[p]) |-> $past(!cmd_lo_n[p], 3));
  end

endmodule

bind arm_interlock arm_interlock_chk #(
  .NUM_PHASES(NUM_PHASES), .DEAD_CYCLES(DEAD_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .cmd_hi_n(cmd_hi_n), .cmd_lo_n(cmd_lo_n),
  .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_n(fault_n)
);

// File: tb/arm_interlock_tb.sv
module arm_interlock_tb;

  localparam int NP   = 3;
  localparam int DEAD = 6;
  localparam int HOLD = 16;
  localparam int NV   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] cmd_hi_n = '1, cmd_lo_n = '1;
  logic [NP-1:0] gate_hi, gate_lo;
  logic fault_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  arm_interlock #(.NUM_PHASES(NP), .DEAD_CYCLES(DEAD)) u_dut (
    .clk(clk), .rst(rst), .cmd_hi_n(cmd_hi_n), .cmd_lo_n(cmd_lo_n),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_n(fault_n));

  // {hi_n, lo_n, exp gate_hi, exp gate_lo, exp fault_n}; bit i = phase i
  localparam logic [12:0] VEC [NV] = '{
    {3'b110, 3'b111, 3'b001, 3'b000, 1'b1},  // 0  R1 ph0 high on
    {3'b111, 3'b110, 3'b000, 3'b001, 1'b1},  // 1  R1 ph0 swap to low
    {3'b101, 3'b110, 3'b010, 3'b001, 1'b1},  // 2  R1 ph1 high on
    {3'b001, 3'b110, 3'b110, 3'b001, 1'b1},  // 3  R1 ph2 high on
    {3'b001, 3'b010, 3'b010, 3'b001, 1'b0},  // 4  R3 R7 ph2 low joins, trip
    {3'b001, 3'b110, 3'b010, 3'b001, 1'b0},  // 5  R4 legal again, held
    {3'b101, 3'b110, 3'b010, 3'b001, 1'b0},  // 6  R4 all off on ph2, held
    {3'b001, 3'b110, 3'b010, 3'b001, 1'b0},  // 7  R5 earlier input edge, held
    {3'b101, 3'b110, 3'b010, 3'b001, 1'b0},  // 8  R5
    {3'b101, 3'b010, 3'b010, 3'b101, 1'b1},  // 9  R5 later input edge, release
    {3'b111, 3'b111, 3'b000, 3'b000, 1'b1},  // 10 R1 all off
    {3'b110, 3'b110, 3'b000, 3'b000, 1'b0},  // 11 R6 both at once, trip
    {3'b110, 3'b111, 3'b000, 3'b000, 1'b0},  // 12 R4 held
    {3'b111, 3'b111, 3'b000, 3'b000, 1'b0},  // 13 R4 held
    {3'b111, 3'b110, 3'b000, 3'b001, 1'b1},  // 14 R6 low edge releases
    {3'b111, 3'b111, 3'b000, 3'b000, 1'b1}   // 15 R1
  };
  localparam int VREQ [NV] = '{1, 1, 1, 1, 3, 4, 4, 5, 5, 5, 1, 6, 4, 4, 6, 1};

  task automatic check(input logic [NP-1:0] eh, input logic [NP-1:0] el,
                       input logic ef, input string tag);
    checks++;
    if (gate_hi !== eh || gate_lo !== el || fault_n !== ef) begin
      fails++;
      $display("FAIL %s: gate_hi=%b gate_lo=%b fault_n=%b, expected %b %b %b",
               tag, gate_hi, gate_lo, fault_n, eh, el, ef);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
    end
  end

  initial begin
    wait_neg(3);
    check('0, '0, 1'b1, "R9 reset state");
    rst = 1'b0;
    wait_neg(HOLD);
    check('0, '0, 1'b1, "R9 idle after reset");

    for (int v = 0; v < NV; v++) begin
      cmd_hi_n = VEC[v][12:10];
      cmd_lo_n = VEC[v][9:7];
      wait_neg(HOLD);
      check(VEC[v][6:4], VEC[v][3:1], VEC[v][0], $sformatf("R%0d vector %0d", VREQ[v], v));
    end

    // R1 latency: ph1 high side turns on at the third edge
    cmd_hi_n = 3'b101;
    wait_neg(2);
    check(3'b000, 3'b000, 1'b1, "R1 gate not yet on after 2 edges");
    wait_neg(1);
    check(3'b010, 3'b000, 1'b1, "R1 gate on after 3 edges");
    wait_neg(HOLD);

    // R3 trip latency and R7 independence
    cmd_lo_n = 3'b101;
    wait_neg(2);
    check(3'b010, 3'b000, 1'b1, "R3 before trip edge");
    wait_neg(1);
    check(3'b000, 3'b000, 1'b0, "R3 trip cuts leg and flags fault");

    // R9 reset clears a latched trip
    cmd_hi_n = '1;
    cmd_lo_n = '1;
    rst = 1'b1;
    wait_neg(2);
    rst = 1'b0;
    check('0, '0, 1'b1, "R9 reset clears trip");
    wait_neg(HOLD);

    // R8 exact dead time on a direct low-to-high swap of ph0
    cmd_lo_n = 3'b110;
    wait_neg(HOLD);
    check(3'b000, 3'b001, 1'b1, "R8 setup low on");
    cmd_lo_n = 3'b111;
    cmd_hi_n = 3'b110;
    wait_neg(3);
    check(3'b000, 3'b000, 1'b1, "R8 low gate off");
    wait_neg(DEAD - 1);
    check(3'b000, 3'b000, 1'b1, "R8 high gate held one edge short");
    wait_neg(1);
    check(3'b001, 3'b000, 1'b1, "R8 high gate on at dead time");

    // R2 + R8 reverse direction
    cmd_hi_n = 3'b111;
    cmd_lo_n = 3'b110;
    wait_neg(3 + DEAD - 1);
    check(3'b000, 3'b000, 1'b1, "R8 low gate held one edge short");
    wait_neg(1);
    check(3'b000, 3'b001, 1'b1, "R2 R8 low gate on alone");

    done = 1'b1;
    summary();
  end

endmodule